// File: doc/BRIEF.md
# Predicated Splat Write-Back Sequencer

This block sits behind a scalar execution unit. It takes one scalar result and copies it into a run of vector destination elements. The scalar value, together with its 4-bit condition field, is accepted once through a valid/ready handshake. Element 0 of the destination run is written first, through port 0. A copy phase follows and spreads the same value across the remaining elements. It uses up to four register-file write ports in the same cycle, and a predicate mask gates each element.

An interrupt can stop the sequence. If the first write has already been committed, the block parks with that fact visible on a status output, keeps its record of which elements are still unwritten, and refuses new results. A resume pulse then continues the copy phase where it stopped, without asking for the scalar again. An interrupt that hits the first-write cycle cancels the operation, and the producer must issue it again.

Top module: `splat_wb_seq`

## Requirements
- R1: `res_ready` is high only while the block is idle with no parked operation. A result is taken on a cycle where `res_valid` and `res_ready` are both high, and exactly one result is consumed per operation.
- R2: In the cycle after acceptance, only port 0 is enabled. It writes element 0 to register `dst_base`, whatever the value of mask bit 0.
- R3: The copy phase writes each element i with 1 <= i < `elem_cnt` (1..64) whose bit i of `pred_mask` is 1. It never writes an element whose mask bit is 0 or whose index is at or beyond the count, and it writes no element twice.
- R4: Each copy cycle writes the lowest-indexed pending elements, up to four, in ascending order on ports 0,1,2,3. The enabled ports always form a contiguous group starting at port 0, so masked-off elements occupy no port.
- R5: Every enabled port carries the data and condition field captured at acceptance, even if the result inputs change afterwards.
- R6: The register index on a port is `dst_base` plus the element index, modulo 128.
- R7: `op_done` is high for exactly one cycle, in the cycle after the last write. After that the block is idle with `first_committed` low. If the count is 1, or no copy element is enabled, `op_done` follows the first-write cycle directly.
- R8: `intr` held high during a copy cycle suppresses every write of that cycle. The block then parks with `first_committed` high and `res_ready` low. A later `resume` continues the copy phase with only the elements not yet written.
- R9: `intr` held high during the first-write cycle suppresses that write. The block returns to idle with `first_committed` low and `res_ready` high.
- R10: `resume` has no effect while `first_committed` is low: no port is enabled and the block stays idle.
- R11: After reset, all write enables, `op_done` and `first_committed` are low, and `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Scalar result offered |
| res_ready | output | 1 | Block can take a result |
| res_data | input | 64 | Scalar result value |
| res_cr | input | 4 | Condition field tied to the result |
| pred_mask | input | 64 | Per-element predicate, bit i gates element i |
| dst_base | input | 7 | Register index of element 0 |
| elem_cnt | input | 7 | Number of destination elements, 1..64 |
| intr | input | 1 | Interrupt request, suppresses writes in its cycle |
| resume | input | 1 | Continue a parked copy phase |
| first_committed | output | 1 | First destination write has been committed |
| op_done | output | 1 | One-cycle completion pulse |
| wp_en | output | 4 | Write enable per port |
| wp_idx | output | 28 | Register index per port, port p in bits [7p+6:7p] |
| wp_data | output | 256 | Data per port, port p in bits [64p+63:64p] |
| wp_cr | output | 16 | Condition field per port, port p in bits [4p+3:4p] |

## Verification
The hardest state to reach from the ports is a parked copy phase: it exists only after an interrupt that lands in a copy cycle, after the first write has committed but before the mask has been drained. The stimulus counts cycles from acceptance and raises `intr` in one chosen copy cycle of a long, sparse-mask run. It holds the block parked for several cycles and then pulses `resume`, so the per-cycle port comparison shows that exactly the elements not yet written follow. An interrupt in the first-write cycle, followed by an ignored `resume`, covers the cancelled path.

// File: rtl/splat_pkg.sv
package splat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_COPY  = 2'd2,
    ST_DONE  = 2'd3
  } splat_state_e;
endpackage

// File: rtl/splat_lowbit.sv
// Finds the lowest set bit of a vector: one-hot form and binary position.
module splat_lowbit #(
  parameter int W  = 64,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [PW-1:0] pos,
  output logic [W-1:0]  hot
);
  always_comb begin
    found = |vec;
    hot   = vec & (~vec + {{(W-1){1'b0}}, 1'b1});
    pos   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/splat_ctrl.sv
// Sequencer state machine and first-write commit flag.
module splat_ctrl
  import splat_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic         intr,
  input  logic         resume,
  input  logic         copy_none,
  input  logic         copy_last,
  output splat_state_e state,
  output logic         first_done,
  output logic         res_ready,
  output logic         done
);
  splat_state_e state_d;
  logic         first_d;

  always_comb begin
    state_d = state;
    first_d = first_done;
    unique case (state)
      ST_IDLE: begin
        if (first_done && resume)        state_d = ST_COPY;
        else if (!first_done && res_valid) state_d = ST_FIRST;
      end
      ST_FIRST: begin
        if (intr) state_d = ST_IDLE;
        else begin
          first_d = 1'b1;
          state_d = copy_none ? ST_DONE : ST_COPY;
        end
      end
      ST_COPY: begin
        if (intr)           state_d = ST_IDLE;
        else if (copy_last) state_d = ST_DONE;
      end
      ST_DONE: begin
        first_d = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      first_done <= 1'b0;
    end else begin
      state      <= state_d;
      first_done <= first_d;
    end
  end

  assign res_ready = (state == ST_IDLE) && !first_done;
  assign done      = (state == ST_DONE);

  a_r1_accept_starts_first: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (state == ST_FIRST));

  a_r10_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !first_done && !res_valid) |=> (state == ST_IDLE && !first_done));

  a_r8_resume_reenters_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && first_done && resume) |=> (state == ST_COPY && first_done));

  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE && !first_done));

  a_r9_first_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIRST && intr) |=> (state == ST_IDLE && !first_done));
endmodule

// File: rtl/splat_wb_seq.sv
// Predicated splat write-back sequencer: one scalar, many element writes.
module splat_wb_seq
  import splat_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CR_W     = 4,
  parameter int NPORTS   = 4,
  parameter int MAX_ELEM = 64,
  parameter int IDX_W    = 7,
  localparam int CNT_W   = $clog2(MAX_ELEM + 1),
  localparam int EPOS_W  = (MAX_ELEM > 1) ? $clog2(MAX_ELEM) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     res_valid,
  output logic                     res_ready,
  input  logic [DATA_W-1:0]        res_data,
  input  logic [CR_W-1:0]          res_cr,
  input  logic [MAX_ELEM-1:0]      pred_mask,
  input  logic [IDX_W-1:0]         dst_base,
  input  logic [CNT_W-1:0]         elem_cnt,
  input  logic                     intr,
  input  logic                     resume,
  output logic                     first_committed,
  output logic                     op_done,
  output logic [NPORTS-1:0]        wp_en,
  output logic [NPORTS*IDX_W-1:0]  wp_idx,
  output logic [NPORTS*DATA_W-1:0] wp_data,
  output logic [NPORTS*CR_W-1:0]   wp_cr
);
  splat_state_e        state;
  logic [DATA_W-1:0]   data_q;
  logic [CR_W-1:0]     cr_q;
  logic [IDX_W-1:0]    base_q;
  logic [MAX_ELEM-1:0] pend_q;
  logic [MAX_ELEM-1:0] pend_init;
  logic [MAX_ELEM-1:0] cnt_mask;
  logic [MAX_ELEM-1:0] rem [NPORTS+1];
  logic [NPORTS-1:0]   found;
  logic [EPOS_W-1:0]   pos [NPORTS];
  logic                load_en, step_en, copy_none, copy_last;

  splat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .intr      (intr),
    .resume    (resume),
    .copy_none (copy_none),
    .copy_last (copy_last),
    .state     (state),
    .first_done(first_committed),
    .res_ready (res_ready),
    .done      (op_done)
  );

  // Elements below the count, excluding element 0 which the first write covers.
  always_comb begin
    for (int i = 0; i < MAX_ELEM; i++) begin
      cnt_mask[i] = (i != 0) && (CNT_W'(i) < elem_cnt);
    end
    pend_init = pred_mask & cnt_mask;
  end

  assign load_en   = res_valid && res_ready;
  assign step_en   = (state == ST_COPY) && !intr;
  assign copy_none = (pend_q == '0);
  assign copy_last = (rem[NPORTS] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cr_q   <= '0;
      base_q <= '0;
    end else if (load_en) begin
      data_q <= res_data;
      cr_q   <= res_cr;
      base_q <= dst_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (load_en) pend_q <= pend_init;
    else if (step_en) pend_q <= rem[NPORTS];
  end

  assign rem[0] = pend_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [MAX_ELEM-1:0]    hot;
    logic [IDX_W+EPOS_W-1:0] sum;

    splat_lowbit #(.W(MAX_ELEM)) u_pick (
      .vec  (rem[p]),
      .found(found[p]),
      .pos  (pos[p]),
      .hot  (hot)
    );
    assign rem[p+1] = rem[p] & ~hot;

    always_comb begin
      sum = {{EPOS_W{1'b0}}, base_q} + {{IDX_W{1'b0}}, pos[p]};
      if (p == 0 && state == ST_FIRST) begin
        wp_en[p]                  = !intr;
        wp_idx[p*IDX_W +: IDX_W]  = base_q;
      end else begin
        wp_en[p]                  = step_en && found[p];
        wp_idx[p*IDX_W +: IDX_W]  = sum[IDX_W-1:0];
      end
    end
    assign wp_data[p*DATA_W +: DATA_W] = data_q;
    assign wp_cr[p*CR_W +: CR_W]       = cr_q;
  end

  a_r4_ports_packed: assert property (@(posedge clk) disable iff (!rst_n)
    ((wp_en & (wp_en + 1'b1)) == '0));

  a_r8_intr_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> (wp_en == '0));

  a_r3_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COPY) |=> ((pend_q & ~$past(pend_q)) == '0));

  a_r2_first_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIRST && !intr) |-> ($countones(wp_en) == 1 && wp_en[0]));

  a_r1_ready_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> (wp_en == '0));
endmodule

// File: tb/splat_wb_seq_test.sv
module splat_wb_seq_test;
  localparam int NP = 4;
  localparam int IW = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         res_valid = 1'b0;
  logic         res_ready;
  logic [63:0]  res_data = '0;
  logic [3:0]   res_cr = '0;
  logic [63:0]  pred_mask = '0;
  logic [6:0]   dst_base = '0;
  logic [6:0]   elem_cnt = '0;
  logic         intr = 1'b0;
  logic         resume = 1'b0;
  logic         first_committed, op_done;
  logic [3:0]   wp_en;
  logic [27:0]  wp_idx;
  logic [255:0] wp_data;
  logic [15:0]  wp_cr;

  int checks = 0;
  int errors = 0;
  int lst [64];
  int nlst;

  always #2 clk = ~clk;

  splat_wb_seq uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_cr(res_cr), .pred_mask(pred_mask),
    .dst_base(dst_base), .elem_cnt(elem_cnt), .intr(intr), .resume(resume),
    .first_committed(first_committed), .op_done(op_done), .wp_en(wp_en),
    .wp_idx(wp_idx), .wp_data(wp_data), .wp_cr(wp_cr)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare one cycle of port activity with the next g listed elements.
  task automatic chk_group(input string req, input int start, input int g,
                           input logic [6:0] b, input logic [63:0] d, input logic [3:0] c);
    logic [3:0] exp_en;
    exp_en = 4'((1 << g) - 1);
    chk(wp_en == exp_en, {req, " R4 enables"}, wp_en, exp_en);
    for (int p = 0; p < g; p++) begin
      logic [6:0] ei;
      ei = 7'(b + 7'(lst[start+p]));
      chk(wp_idx[p*IW +: IW] == ei, {req, " R6 index"}, wp_idx[p*IW +: IW], ei);
      chk(wp_data[p*64 +: 64] == d, {req, " R5 data"}, wp_data[p*64 +: 64], d);
      chk(wp_cr[p*4 +: 4] == c, {req, " R5 cr"}, wp_cr[p*4 +: 4], c);
    end
  endtask

  // One complete operation. intr_at counts cycles from the first-write cycle (0).
  task automatic run_op(input string name, input logic [63:0] d, input logic [3:0] c,
                        input logic [63:0] m, input logic [6:0] b, input int cnt,
                        input int intr_at, input int park_cyc);
    int st, ptr, cyc, parked, g;
    bit fin;
    nlst = 0;
    for (int i = 1; i < cnt; i++) if (m[i]) begin lst[nlst] = i; nlst++; end
    @(negedge clk);
    chk(res_ready == 1'b1, {name, " R1 ready before op"}, res_ready, 1);
    res_valid = 1'b1; res_data = d; res_cr = c; pred_mask = m;
    dst_base = b; elem_cnt = 7'(cnt);
    @(negedge clk);
    res_valid = 1'b0; res_data = ~d; res_cr = ~c; pred_mask = '0; dst_base = ~b;
    st = 0; ptr = 0; cyc = 0; parked = 0; fin = 1'b0;
    while (!fin) begin
      intr   = (cyc == intr_at);
      resume = (st == 3 && parked >= park_cyc) || (st == 4);
      #1;
      if (st != 2) chk(op_done == 1'b0, {name, " R7 no early done"}, op_done, 0);
      chk(res_ready == 1'b0 || st == 4 || st == 5, {name, " R1 ready while busy"}, res_ready, 0);
      case (st)
        0: begin
          chk(first_committed == 1'b0, {name, " R2 flag before first"}, first_committed, 0);
          if (intr) begin
            chk(wp_en == 4'b0, {name, " R9 first write suppressed"}, wp_en, 0);
            st = 4;
          end else begin
            nlst = nlst; // first write is element 0
            chk(wp_en == 4'b0001, {name, " R2 first port only"}, wp_en, 1);
            chk(wp_idx[IW-1:0] == b, {name, " R2 first index"}, wp_idx[IW-1:0], b);
            chk(wp_data[63:0] == d, {name, " R5 first data"}, wp_data[63:0], d);
            chk(wp_cr[3:0] == c, {name, " R5 first cr"}, wp_cr[3:0], c);
            st = (nlst == 0) ? 2 : 1;
          end
        end
        1: begin
          chk(first_committed == 1'b1, {name, " R8 flag in copy"}, first_committed, 1);
          if (intr) begin
            chk(wp_en == 4'b0, {name, " R8 copy write suppressed"}, wp_en, 0);
            st = 3; parked = 0;
          end else begin
            g = (nlst - ptr > NP) ? NP : nlst - ptr;
            chk_group({name, " R3 copy"}, ptr, g, b, d, c);
            ptr += g;
            st = (ptr == nlst) ? 2 : 1;
          end
        end
        2: begin
          chk(op_done == 1'b1, {name, " R7 done pulse"}, op_done, 1);
          chk(wp_en == 4'b0, {name, " R7 no write in done"}, wp_en, 0);
          fin = 1'b1;
        end
        3: begin
          chk(wp_en == 4'b0, {name, " R8 parked quiet"}, wp_en, 0);
          chk(res_ready == 1'b0, {name, " R8 parked not ready"}, res_ready, 0);
          chk(first_committed == 1'b1, {name, " R8 parked flag"}, first_committed, 1);
          if (resume) st = 1; else parked++;
        end
        4: begin
          chk(first_committed == 1'b0, {name, " R9 flag low after abort"}, first_committed, 0);
          chk(res_ready == 1'b1, {name, " R9 ready after abort"}, res_ready, 1);
          chk(wp_en == 4'b0, {name, " R10 resume pulse quiet"}, wp_en, 0);
          st = 5;
        end
        default: begin
          chk(wp_en == 4'b0, {name, " R10 resume ignored"}, wp_en, 0);
          chk(res_ready == 1'b1, {name, " R10 still idle"}, res_ready, 1);
          fin = 1'b1;
        end
      endcase
      @(negedge clk);
      intr = 1'b0; resume = 1'b0; cyc++;
    end
    #1;
    chk(res_ready == 1'b1, {name, " R7 idle after op"}, res_ready, 1);
    chk(first_committed == 1'b0, {name, " R7 flag cleared"}, first_committed, 0);
  endtask

  task automatic t_reset;
    #1;
    chk(wp_en == 4'b0, "R11 enables low", wp_en, 0);
    chk(op_done == 1'b0, "R11 done low", op_done, 0);
    chk(first_committed == 1'b0, "R11 flag low", first_committed, 0);
    chk(res_ready == 1'b1, "R11 ready high", res_ready, 1);
  endtask

  task automatic t_idle_resume;
    @(negedge clk);
    resume = 1'b1;
    #1;
    chk(wp_en == 4'b0, "R10 idle resume no write", wp_en, 0);
    @(negedge clk);
    resume = 1'b0;
    #1;
    chk(wp_en == 4'b0, "R10 idle resume stays idle", wp_en, 0);
    chk(res_ready == 1'b1, "R10 ready after resume", res_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_op("full9", 64'h1122_3344_5566_7788, 4'h5, '1, 7'd10, 9, -1, 0);
    run_op("sparse16", 64'hDEAD_BEEF_0BAD_F00D, 4'hA, 64'hA5A5_A5A5_A5A5_A5A5, 7'd3, 16, -1, 0);
    run_op("count1", 64'h0123_4567_89AB_CDEF, 4'h3, '1, 7'd50, 1, -1, 0);
    run_op("allmasked", 64'hFFFF_0000_FFFF_0000, 4'hC, 64'h1, 7'd20, 8, -1, 0);
    run_op("beyondcnt", 64'h5555_AAAA_5555_AAAA, 4'h9, 64'hFFFF_FF00_0000_0001, 7'd0, 8, -1, 0);
    run_op("full64wrap", 64'hCAFE_D00D_1234_5678, 4'hF, '1, 7'd100, 64, -1, 0);
    run_op("intrcopy", 64'h0F0F_F0F0_3C3C_C3C3, 4'h6, 64'hF0F3_0F0C_9999_6666, 7'd64, 64, 2, 3);
    run_op("intrfirst", 64'h7777_8888_9999_AAAA, 4'h1, '1, 7'd5, 12, 0, 0);
    run_op("afterabort", 64'h1357_9BDF_2468_ACE0, 4'h2, 64'h0000_0000_0000_0F0E, 7'd120, 12, 1, 0);
    t_idle_resume();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule